// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the state machine at the heart of a chip's power controller. Software writes a command code into a 16-bit mode field to enter one of three low-power modes: sleep, stop or deep stop. For sleep, the sequencer steps through a chain of request/acknowledge handshakes. The CPU's bus traffic drains first. Then the CPU clock is gated, the system bus drains and the DRAM enters self-refresh. After that the system clocks stop, isolation goes on, the external regulator is told to power down and the oscillator and PLL are switched off. For stop and deep stop, it gates every clock and then switches the oscillator and PLL off. Deep stop also removes power from the CPU and holds the CPU in reset.

A wake event brings the chip back. From sleep, the regulator is re-enabled first. A programmable settle count then runs, and the system reset is pulled low for the rest of the wake-up. From stop, the path is shorter: CPU power is restored first when leaving deep stop. In every case the oscillator is enabled and given a fixed settle time. The PLL then locks while the bus clocks run from the raw input clock. The clock source then switches to the PLL, and the CPU clock and the resets are released on the last step.

The oscillator, PLL, regulator and the bus and memory controllers are outside this block. They appear only as handshake inputs and enable outputs.

Top module: `pwr_seq`

## Requirements
- R1: After reset, state_o is 0 (run). All clock enables, osc_en, pll_en, clk_sel, sys_rst_n and cpu_rst_n are 1. All requests, iso_en, pwr_en and cpu_pwr_en_n are 0. The settle field resets to 8.
- R2: In the run state, a write with cfg_sel=0 acts on its data. Code 16'h5A5A starts sleep (state 1), 16'h0F0F starts stop (state 10) and 16'h0FF0 starts deep stop (state 10). Any other code, and any mode write made outside the run state, is ignored.
- R3: In state 1, cpu_drain_req is 1 and the CPU clock stays on. The cycle after cpu_drain_ack is seen, cpu_clk_en falls and bus_drain_req rises (state 2).
- R4: The cycle after bus_idle_ack is seen in state 2, sr_req rises (state 3). hclk_en and pclk_en stay on until sr_ack is seen.
- R5: The cycle after sr_ack, hclk_en and pclk_en fall (state 4). The entry then takes one cycle per step: iso_en rises (state 5), then pwr_en rises (state 6), then osc_en, pll_en and clk_sel fall (state 7, sleep).
- R6: wake is sampled only in state 7 (sleep) and state 11 (stop). In every other state it has no effect.
- R7: A wake in sleep drops pwr_en in the next cycle (state 8) while isolation holds. State 8 lasts settle+1 cycles, where settle is the last value written with cfg_sel=1.
- R8: On leaving state 8, sys_rst_n falls and all three requests drop in the same cycle. sys_rst_n stays low through the oscillator, PLL and switch states. It rises, with iso_en falling, in state 15.
- R9: The wake-up path runs the same way from every mode. State 12 lasts OSC_CYC cycles with osc_en=1 and pll_en=0. State 13 lasts PLL_CYC cycles with pll_en, hclk_en and pclk_en at 1 and clk_sel at 0. In state 14, clk_sel is 1. In state 15, cpu_clk_en is 1. The state after 15 is run.
- R10: Stop entry spends one cycle in state 10 with all clocks gated while the oscillator and PLL run. It then rests in state 11 with osc_en, pll_en and clk_sel at 0.
- R11: In deep stop, state 11 has cpu_pwr_en_n=1 and cpu_rst_n=0. A wake leads to state 9 for one cycle, with cpu_pwr_en_n back at 0. Then state 12 follows. cpu_rst_n stays 0 until state 15, which comes after hclk_en has been 1.
- R12: state_o encodes the sequencer step as a 4-bit code from 0 to 15 in the numbering used above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0: mode command field, 1: power-settle count field |
| cfg_wdata | input | 16 | Write data |
| wake | input | 1 | Wake-up event |
| cpu_drain_ack | input | 1 | CPU bus traffic drained |
| bus_idle_ack | input | 1 | System bus idle |
| sr_ack | input | 1 | DRAM in self-refresh |
| cpu_drain_req | output | 1 | Request to drain CPU bus traffic |
| bus_drain_req | output | 1 | Request to finish all bus traffic |
| sr_req | output | 1 | Self-refresh request |
| cpu_clk_en | output | 1 | CPU clock enable |
| hclk_en | output | 1 | High-speed bus clock enable |
| pclk_en | output | 1 | Peripheral bus clock enable |
| iso_en | output | 1 | Isolation and retention hold |
| pwr_en | output | 1 | Ready for external power-off (regulator off) |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_sel | output | 1 | 1: PLL output, 0: PLL input clock |
| sys_rst_n | output | 1 | System reset, active low |
| cpu_rst_n | output | 1 | CPU reset, active low |
| cpu_pwr_en_n | output | 1 | CPU power-gate control, 1 removes CPU power |
| state_o | output | 4 | Current sequencer step |

## Verification
The ordering properties assume well-behaved handshake inputs. An acknowledge is raised only while its request is high and stays high until a reset drops it. An acknowledge never arrives before the step that consumes it. The bench's responder follows this rule. It raises each acknowledge a set number of cycles after the request appears, and it clears all acknowledges whenever sys_rst_n is low, as a reset controller would. Wake and command writes are sent as single-cycle pulses. Some arrive in states where they must be ignored, so the property on leaving sleep only ever sees wakes the design should act on.

// File: rtl/pwr_seq.sv
`timescale 1ns/1ps
module pwr_seq #(
  parameter int          OSC_CYC     = 16,
  parameter int          PLL_CYC     = 24,
  parameter logic [15:0] CMD_SLEEP   = 16'h5A5A,
  parameter logic [15:0] CMD_STOP    = 16'h0F0F,
  parameter logic [15:0] CMD_DSTOP   = 16'h0FF0,
  parameter logic [15:0] SETTLE_INIT = 16'd8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [15:0] cfg_wdata,
  input  logic        wake,
  input  logic        cpu_drain_ack,
  input  logic        bus_idle_ack,
  input  logic        sr_ack,
  output logic        cpu_drain_req,
  output logic        bus_drain_req,
  output logic        sr_req,
  output logic        cpu_clk_en,
  output logic        hclk_en,
  output logic        pclk_en,
  output logic        iso_en,
  output logic        pwr_en,
  output logic        osc_en,
  output logic        pll_en,
  output logic        clk_sel,
  output logic        sys_rst_n,
  output logic        cpu_rst_n,
  output logic        cpu_pwr_en_n,
  output logic [3:0]  state_o
);
  localparam int MAXW = OSC_CYC > PLL_CYC ? OSC_CYC : PLL_CYC;
  localparam int LW   = $clog2(MAXW) + 1;
  localparam int CW   = LW > 16 ? LW : 16;
  localparam logic [1:0] K_NONE = 2'd0, K_SLEEP = 2'd1, K_STOP = 2'd2, K_DSTOP = 2'd3;

  typedef enum logic [3:0] {
    S_RUN = 4'd0, S_CPUDN = 4'd1, S_BUSDN = 4'd2, S_SREF = 4'd3,
    S_CLKOFF = 4'd4, S_ISO = 4'd5, S_PWROFF = 4'd6, S_SLEEP = 4'd7,
    S_SETTLE = 4'd8, S_CPUPWR = 4'd9, S_GATE = 4'd10, S_STOP = 4'd11,
    S_OSC = 4'd12, S_PLL = 4'd13, S_SWITCH = 4'd14, S_CPUREL = 4'd15
  } st_t;

  st_t          st;
  logic [1:0]   kind;
  logic [CW-1:0] cnt;
  logic [15:0]  settle;
  logic         mode_wr, wake_path;

  assign mode_wr = cfg_we && !cfg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      kind   <= K_NONE;
      cnt    <= '0;
      settle <= SETTLE_INIT;
    end else begin
      if (cfg_we && cfg_sel) settle <= cfg_wdata;
      case (st)
        S_RUN:
          if (mode_wr) begin
            if (cfg_wdata == CMD_SLEEP) begin
              st <= S_CPUDN; kind <= K_SLEEP;
            end else if (cfg_wdata == CMD_STOP) begin
              st <= S_GATE; kind <= K_STOP;
            end else if (cfg_wdata == CMD_DSTOP) begin
              st <= S_GATE; kind <= K_DSTOP;
            end
          end
        S_CPUDN:  if (cpu_drain_ack) st <= S_BUSDN;
        S_BUSDN:  if (bus_idle_ack) st <= S_SREF;
        S_SREF:   if (sr_ack) st <= S_CLKOFF;
        S_CLKOFF: st <= S_ISO;
        S_ISO:    st <= S_PWROFF;
        S_PWROFF: st <= S_SLEEP;
        S_SLEEP:
          if (wake) begin
            st  <= S_SETTLE;
            cnt <= CW'(settle);
          end
        S_SETTLE:
          if (cnt == '0) begin
            st  <= S_OSC;
            cnt <= CW'(OSC_CYC - 1);
          end else cnt <= cnt - 1'b1;
        S_GATE:   st <= S_STOP;
        S_STOP:
          if (wake) begin
            if (kind == K_DSTOP) st <= S_CPUPWR;
            else begin
              st  <= S_OSC;
              cnt <= CW'(OSC_CYC - 1);
            end
          end
        S_CPUPWR: begin
          st  <= S_OSC;
          cnt <= CW'(OSC_CYC - 1);
        end
        S_OSC:
          if (cnt == '0) begin
            st  <= S_PLL;
            cnt <= CW'(PLL_CYC - 1);
          end else cnt <= cnt - 1'b1;
        S_PLL:
          if (cnt == '0) st <= S_SWITCH;
          else cnt <= cnt - 1'b1;
        S_SWITCH: st <= S_CPUREL;
        S_CPUREL: begin
          st   <= S_RUN;
          kind <= K_NONE;
        end
        default:  st <= S_RUN;
      endcase
    end
  end

  assign wake_path = st inside {S_OSC, S_PLL, S_SWITCH};

  assign cpu_drain_req = st inside {S_CPUDN, S_BUSDN, S_SREF, S_CLKOFF, S_ISO, S_PWROFF, S_SLEEP, S_SETTLE};
  assign bus_drain_req = st inside {S_BUSDN, S_SREF, S_CLKOFF, S_ISO, S_PWROFF, S_SLEEP, S_SETTLE};
  assign sr_req        = st inside {S_SREF, S_CLKOFF, S_ISO, S_PWROFF, S_SLEEP, S_SETTLE};

  assign cpu_clk_en = st inside {S_RUN, S_CPUDN, S_CPUREL};
  assign hclk_en    = st inside {S_RUN, S_CPUDN, S_BUSDN, S_SREF, S_PLL, S_SWITCH, S_CPUREL};
  assign pclk_en    = hclk_en;

  assign iso_en = (st inside {S_ISO, S_PWROFF, S_SLEEP, S_SETTLE}) || (kind == K_SLEEP && wake_path);
  assign pwr_en = st inside {S_PWROFF, S_SLEEP};

  assign osc_en  = !(st inside {S_SLEEP, S_SETTLE, S_CPUPWR, S_STOP});
  assign pll_en  = osc_en && (st != S_OSC);
  assign clk_sel = !(st inside {S_SLEEP, S_SETTLE, S_CPUPWR, S_STOP, S_OSC, S_PLL});

  assign sys_rst_n    = !(kind == K_SLEEP && wake_path);
  assign cpu_rst_n    = sys_rst_n && !(kind == K_DSTOP && (wake_path || st inside {S_STOP, S_CPUPWR}));
  assign cpu_pwr_en_n = (kind == K_DSTOP) && (st == S_STOP);

  assign state_o = st;
endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wake,
  input logic       cpu_drain_ack,
  input logic       sr_ack,
  input logic       cpu_drain_req,
  input logic       bus_drain_req,
  input logic       sr_req,
  input logic       cpu_clk_en,
  input logic       hclk_en,
  input logic       iso_en,
  input logic       pwr_en,
  input logic       osc_en,
  input logic       sys_rst_n,
  input logic       cpu_rst_n,
  input logic [3:0] state_o
);
  AST_CPU_GATE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_drain_req && $fell(cpu_clk_en)) |-> $past(cpu_drain_ack)); // R3
  AST_BUS_AFTER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drain_req |-> (cpu_drain_req && !cpu_clk_en)); // R4
  AST_SREF_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    sr_req |-> bus_drain_req); // R4
  AST_CLK_AFTER_SREF: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_req && $fell(hclk_en)) |-> $past(sr_ack)); // R5
  AST_PWR_AFTER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> (iso_en && !hclk_en)); // R5
  AST_OSC_AFTER_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(osc_en) && iso_en) |-> $past(pwr_en)); // R5
  AST_WAKE_LEAVES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 4'd7 && state_o != 4'd7) |-> $past(wake)); // R6
  AST_REQ_DROP_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sr_req) && !sr_req) |-> !sys_rst_n); // R8
  AST_CPU_RST_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> $past(hclk_en)); // R11
endmodule

bind pwr_seq pwr_seq_chk u_chk (.*);

// File: tb/sim_pwr_seq.sv
`timescale 1ns/1ps
module sim_pwr_seq;
  localparam int OSC = 5, PLL = 7;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0, wake = 0;
  logic [15:0] cfg_wdata = '0;
  logic cpu_ack = 0, bus_ack = 0, sr_ack = 0;
  logic cdr, bdr, srr, cclk, hclk, pclk, iso, pwr, osc, pll, sel, srst_n, crst_n, cpwr_n;
  logic [3:0] state_o;

  int errors = 0, checks = 0, cyc = 0, lag = 2;
  int m_st = 0, m_kind = 0, m_age = 0, m_dur = 0, m_settle = 8;
  int ccnt = 0, bcnt = 0, scnt = 0;

  always #2.5 clk = ~clk;

  pwr_seq #(.OSC_CYC(OSC), .PLL_CYC(PLL)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .wake(wake), .cpu_drain_ack(cpu_ack), .bus_idle_ack(bus_ack), .sr_ack(sr_ack),
    .cpu_drain_req(cdr), .bus_drain_req(bdr), .sr_req(srr), .cpu_clk_en(cclk),
    .hclk_en(hclk), .pclk_en(pclk), .iso_en(iso), .pwr_en(pwr), .osc_en(osc),
    .pll_en(pll), .clk_sel(sel), .sys_rst_n(srst_n), .cpu_rst_n(crst_n),
    .cpu_pwr_en_n(cpwr_n), .state_o(state_o));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // expected output vector:
  // {cdr,bdr,srr,cclk,hclk,pclk,iso,pwr,osc,pll,sel,srst_n,crst_n,cpwr_n}
  function automatic logic [13:0] exp_out(input int s, input int k);
    logic sl, dp;
    sl = (k == 1);
    dp = (k == 3);
    case (s)
      0:  return 14'b000_111_00_111_11_0;
      1:  return 14'b100_111_00_111_11_0;
      2:  return 14'b110_011_00_111_11_0;
      3:  return 14'b111_011_00_111_11_0;
      4:  return 14'b111_000_00_111_11_0;
      5:  return 14'b111_000_10_111_11_0;
      6:  return 14'b111_000_11_111_11_0;
      7:  return 14'b111_000_11_000_11_0;
      8:  return 14'b111_000_10_000_11_0;
      9:  return 14'b000_000_00_000_10_0;
      10: return 14'b000_000_00_111_11_0;
      11: return {11'b000_000_00_000, 1'b1, !dp, dp};
      12: return {6'b000_000, sl, 1'b0, 3'b100, !sl, !(sl || dp), 1'b0};
      13: return {6'b000_011, sl, 1'b0, 3'b110, !sl, !(sl || dp), 1'b0};
      14: return {6'b000_011, sl, 1'b0, 3'b111, !sl, !(sl || dp), 1'b0};
      default: return 14'b000_111_00_111_11_0;
    endcase
  endfunction

  function automatic string tag_of(input int s, input int k);
    if (s == 0) return "R2";
    if (s == 1) return "R3";
    if (s == 2 || s == 3) return "R4";
    if (s >= 4 && s <= 7) return "R5";
    if (s == 8) return "R7";
    if (s == 9 || (k == 3 && s == 11)) return "R11";
    if (s == 10 || s == 11) return "R10";
    if (k == 1 && s >= 12) return "R8";
    return "R9";
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_kind = 0; m_age = 0; m_dur = 0; m_settle = 8;
    end else begin
      int nst;
      nst = m_st;
      case (m_st)
        0: if (cfg_we && !cfg_sel) begin
             if (cfg_wdata == 16'h5A5A) begin nst = 1; m_kind = 1; end
             else if (cfg_wdata == 16'h0F0F) begin nst = 10; m_kind = 2; end
             else if (cfg_wdata == 16'h0FF0) begin nst = 10; m_kind = 3; end
           end
        1: if (cpu_ack) nst = 2;
        2: if (bus_ack) nst = 3;
        3: if (sr_ack) nst = 4;
        4, 5, 6: nst = m_st + 1;
        7: if (wake) begin nst = 8; m_dur = m_settle + 1; end
        8: if (m_age == m_dur - 1) begin nst = 12; m_dur = OSC; end
        10: nst = 11;
        11: if (wake) begin
              if (m_kind == 3) nst = 9;
              else begin nst = 12; m_dur = OSC; end
            end
        9: begin nst = 12; m_dur = OSC; end
        12: if (m_age == m_dur - 1) begin nst = 13; m_dur = PLL; end
        13: if (m_age == m_dur - 1) nst = 14;
        14: nst = 15;
        15: begin nst = 0; m_kind = 0; end
        default: nst = 0;
      endcase
      if (cfg_we && cfg_sel) m_settle = cfg_wdata;
      if (nst != m_st) m_age = 0; else m_age++;
      m_st = nst;
    end
  end

  // handshake responder: ack after lag cycles, cleared by system reset
  always @(negedge clk) begin
    if (!srst_n) begin
      ccnt = 0; bcnt = 0; scnt = 0; cpu_ack = 0; bus_ack = 0; sr_ack = 0;
    end else begin
      ccnt = cdr ? ccnt + 1 : 0;
      bcnt = bdr ? bcnt + 1 : 0;
      scnt = srr ? scnt + 1 : 0;
      cpu_ack = cdr && ccnt > lag;
      bus_ack = bdr && bcnt > lag;
      sr_ack  = srr && scnt > lag;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [13:0] act, exp;
      act = {cdr, bdr, srr, cclk, hclk, pclk, iso, pwr, osc, pll, sel, srst_n, crst_n, cpwr_n};
      exp = exp_out(m_st, m_kind);
      chk(state_o == 4'(m_st), {"R12 state in ", tag_of(m_st, m_kind)}, 32'(state_o), 32'(m_st));
      chk(act == exp, {"outputs ", tag_of(m_st, m_kind)}, 32'(act), 32'(exp));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL R12: watchdog expired, state actual=%0d expected=%0d", state_o, m_st);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input bit s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    wake = 1;
    @(negedge clk);
    wake = 0;
  endtask

  task automatic wait_state(input int s, input string tag);
    int g = 0;
    while (state_o !== 4'(s) && g < 2000) begin
      @(negedge clk);
      g++;
    end
    chk(g < 2000, tag, 32'(state_o), 32'(s));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(state_o == 4'd0, "R1 reset state", 32'(state_o), 0);
    chk({cdr, bdr, srr, iso, pwr, cpwr_n} == 6'b0, "R1 reset quiet outputs",
        32'({cdr, bdr, srr, iso, pwr, cpwr_n}), 0);
    chk({cclk, hclk, pclk, osc, pll, sel, srst_n, crst_n} == 8'hFF, "R1 reset enables",
        32'({cclk, hclk, pclk, osc, pll, sel, srst_n, crst_n}), 32'hFF);

    wr(0, 16'h1234);
    pulse_wake();
    @(negedge clk);
    chk(state_o == 4'd0, "R2 unknown code ignored / R6 wake in run ignored", 32'(state_o), 0);

    // sleep with settle 3 and slow acknowledges
    wr(1, 16'd3);
    wr(0, 16'h5A5A);
    pulse_wake();
    wait_state(7, "R5 reach sleep");
    wr(0, 16'h0F0F);
    repeat (2) @(negedge clk);
    chk(state_o == 4'd7, "R2 mode write outside run ignored / R6", 32'(state_o), 7);
    pulse_wake();
    wait_state(8, "R7 settle entered");
    wait_state(12, "R8 reset during wake-up");
    chk(!srst_n && !cdr && !bdr && !srr, "R8 reset with requests dropped",
        32'({srst_n, cdr, bdr, srr}), 0);
    wait_state(0, "R9 back to run");

    // plain stop
    wr(0, 16'h0F0F);
    wait_state(11, "R10 stop reached");
    repeat (4) @(negedge clk);
    pulse_wake();
    wait_state(0, "R9 stop wake-up done");

    // deep stop
    wr(0, 16'h0FF0);
    wait_state(11, "R11 deep stop reached");
    chk(cpwr_n && !crst_n, "R11 CPU unpowered in deep stop", 32'({cpwr_n, crst_n}), 32'h2);
    pulse_wake();
    wait_state(0, "R11 deep stop wake-up done");

    // fast sleep, zero settle, immediate acknowledges
    lag = 0;
    wr(1, 16'd0);
    wr(0, 16'h5A5A);
    wait_state(7, "R5 fast sleep reached");
    pulse_wake();
    wait_state(0, "R7 zero settle wake done");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule